// File: doc/BRIEF.md
# Flash Bus Strobe Gating

This block sits in front of the command logic of a NOR-style flash memory model. It samples the asynchronous active-low chip-enable, output-enable and write-enable strobes and the hardware reset pin with a local sampling clock. Each strobe passes through a synchronizer and a pulse-width filter. From the filtered strobes the block decides when a bus write cycle has completed and may be handed to the command decoder. It also decides when the data bus may be driven and when the part is in standby.

The hardware reset pin, a low-supply lockout flag and a power-up lockout all take precedence over normal bus decoding. A reset pulse of sufficient width, or an active lockout flag, holds the command state machine in array-read mode. When such a reset or lockout begins, the block aborts any embedded program or erase that is running. The command decoder reports that an embedded operation is running on a busy input, and the block uses it to keep the part out of standby while the operation finishes.

Top module: `flash_bus_gate`

## Requirements
- R1: When the reset pin has been sampled low for RST_MIN_CYC consecutive cycles after synchronization, sm_reset_o is high and dq_oe_o is low for as long as the pin stays low. If busy_i is high when that condition is first reached, abort_o pulses high for exactly one cycle.
- R2: While the synchronized reset pin is low, no write is accepted, whatever its pulse width. A reset pulse shorter than RST_MIN_CYC samples neither asserts sm_reset_o nor pulses abort_o.
- R3: While the synchronized low-supply flag is high, no write is accepted and sm_reset_o is high. abort_o pulses once when the flag rises while busy_i is high. Once the flag clears, writes are accepted again.
- R4: A strobe level held for fewer than GLITCH_CYC consecutive samples is discarded by the filter, so such a pulse on the write or chip-enable strobe completes no write.
- R5: A write cycle is open while both filtered CE# and WE# are low. It completes on the first sample in which either of them has risen. wr_accept_o then pulses for one cycle if OE# is high. With OE# low, the completion is discarded.
- R6: From power-on reset until the synchronizers and filters have settled and CE# and WE# have both been seen high, no write is accepted and sm_reset_o is high. This covers a rising WE# edge after power-up with CE# low and OE# high.
- R7: dq_oe_o is high exactly when filtered CE# and OE# are both low and no qualified reset (R1) is active.
- R8: standby_o is high when filtered CE# and the synchronized reset pin are both high and busy_i is low. A deselect while busy_i is high keeps standby_o low until busy_i falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | sampling clock |
| por_n | input | 1 | power-on reset, active low, asynchronous |
| ce_n_i | input | 1 | chip-enable strobe, active low, asynchronous |
| oe_n_i | input | 1 | output-enable strobe, active low, asynchronous |
| we_n_i | input | 1 | write-enable strobe, active low, asynchronous |
| rst_pin_n_i | input | 1 | hardware reset pin, active low, asynchronous |
| vlow_i | input | 1 | low-supply lockout flag, active high, asynchronous |
| busy_i | input | 1 | embedded program or erase running (synchronous) |
| wr_accept_o | output | 1 | one-cycle pulse: a bus write cycle completed |
| dq_oe_o | output | 1 | data outputs may drive |
| sm_reset_o | output | 1 | hold command state machine in array-read mode |
| abort_o | output | 1 | one-cycle pulse: terminate embedded operation |
| standby_o | output | 1 | part is in standby |

## Verification
Writes are driven both ways, once ending on a WE# rise and once ending on a CE# rise. This shows that either edge can close a cycle and that a cycle is counted only once. A write with OE# low separates bus decoding from qualification. Short high glitches on WE# and short low glitches on CE# inside otherwise valid sequences separate the filter from the edge detector. Short and long reset pulses, the supply flag, and the power-up pattern with WE#, CE# and RESET# held low each show which lockout blocks the write, and whether it also resets the state machine or aborts a busy operation.

// File: rtl/fbg_pkg.sv
package fbg_pkg;
   // Index of each filtered strobe inside the strobe vector
   typedef enum int unsigned {
      STB_CE = 0,
      STB_OE = 1,
      STB_WE = 2
   } stb_idx_e;

   localparam int unsigned NUM_STB = 3;
   // Synchronized vector: strobes, then reset pin, then supply flag
   localparam int unsigned SYNC_RST_IDX  = NUM_STB;
   localparam int unsigned SYNC_VLOW_IDX = NUM_STB + 1;
   localparam int unsigned SYNC_W        = NUM_STB + 2;
endpackage

// File: rtl/fbg_sync.sv
module fbg_sync #(
   parameter int unsigned         WIDTH   = 1,
   parameter int unsigned         STAGES  = 2,
   parameter logic [WIDTH-1:0]    RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   initial begin
      assert (STAGES >= 2) else $fatal(1, "fbg_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] pipe [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe[0] <= RST_VAL;
      else        pipe[0] <= d_i;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pipe[s] <= RST_VAL;
         else        pipe[s] <= pipe[s-1];
      end
   end

   assign q_o = pipe[STAGES-1];
endmodule

// File: rtl/fbg_filt.sv
module fbg_filt #(
   parameter int unsigned HOLD    = 4,
   parameter logic        RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic x_i,
   output logic y_o
);
   initial begin
      assert (HOLD >= 1) else $fatal(1, "fbg_filt: HOLD must be at least 1");
   end

   logic y_q;

   if (HOLD == 1) begin : g_pass
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) y_q <= RST_VAL;
         else        y_q <= x_i;
      end
   end else begin : g_count
      localparam int unsigned CW = $clog2(HOLD);
      localparam logic [CW-1:0] LAST = CW'(HOLD - 1);
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            y_q   <= RST_VAL;
            cnt_q <= '0;
         end else if (x_i == y_q) begin
            cnt_q <= '0;
         end else if (cnt_q == LAST) begin
            y_q   <= x_i;
            cnt_q <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign y_o = y_q;

   // R4: the filtered level only ever moves to the level just sampled
   a_r4_follow_input: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(y_q) |-> (y_q == $past(x_i)));
endmodule

// File: rtl/fbg_rst_timer.sv
module fbg_rst_timer #(
   parameter int unsigned MIN_CYC = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_s_i,
   output logic hit_o
);
   initial begin
      assert (MIN_CYC >= 1) else $fatal(1, "fbg_rst_timer: MIN_CYC must be at least 1");
   end

   localparam int unsigned CW = (MIN_CYC > 1) ? $clog2(MIN_CYC) : 1;
   localparam logic [CW-1:0] LAST = CW'(MIN_CYC - 1);

   logic [CW-1:0] cnt_q;
   logic          hit_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         hit_q <= 1'b0;
      end else if (pin_s_i) begin
         cnt_q <= '0;
         hit_q <= 1'b0;
      end else if (!hit_q) begin
         if (cnt_q == LAST) hit_q <= 1'b1;
         else               cnt_q <= cnt_q + 1'b1;
      end
   end

   assign hit_o = hit_q;

   // R1: qualification only rises after the pin was low on two samples in a row
   a_r1_needs_low: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hit_q) |-> (!pin_s_i && $past(!pin_s_i)));
   // R2: a released pin clears qualification on the next sample
   a_r2_release_clears: assert property (@(posedge clk) disable iff (!rst_n)
      pin_s_i |=> !hit_q);
endmodule

// File: rtl/flash_bus_gate.sv
module flash_bus_gate #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned GLITCH_CYC  = 4,
   parameter int unsigned RST_MIN_CYC = 16
) (
   input  logic clk,
   input  logic por_n,
   input  logic ce_n_i,
   input  logic oe_n_i,
   input  logic we_n_i,
   input  logic rst_pin_n_i,
   input  logic vlow_i,
   input  logic busy_i,
   output logic wr_accept_o,
   output logic dq_oe_o,
   output logic sm_reset_o,
   output logic abort_o,
   output logic standby_o
);
   import fbg_pkg::*;

   localparam int unsigned SETTLE   = SYNC_STAGES + GLITCH_CYC + 2;
   localparam int unsigned SW       = $clog2(SETTLE + 1);
   localparam logic [SW-1:0] SETTLE_V = SW'(SETTLE);

   initial begin
      assert (GLITCH_CYC >= 1)  else $fatal(1, "flash_bus_gate: GLITCH_CYC must be at least 1");
      assert (RST_MIN_CYC >= 1) else $fatal(1, "flash_bus_gate: RST_MIN_CYC must be at least 1");
   end

   // ---------------- synchronization ----------------
   logic [SYNC_W-1:0] raw_in, sync_q;
   assign raw_in[STB_CE]        = ce_n_i;
   assign raw_in[STB_OE]        = oe_n_i;
   assign raw_in[STB_WE]        = we_n_i;
   assign raw_in[SYNC_RST_IDX]  = rst_pin_n_i;
   assign raw_in[SYNC_VLOW_IDX] = vlow_i;

   fbg_sync #(
      .WIDTH  (SYNC_W),
      .STAGES (SYNC_STAGES),
      .RST_VAL({SYNC_W{1'b1}})
   ) u_sync (
      .clk  (clk),
      .rst_n(por_n),
      .d_i  (raw_in),
      .q_o  (sync_q)
   );

   logic rst_s, vlow_s;
   assign rst_s  = sync_q[SYNC_RST_IDX];
   assign vlow_s = sync_q[SYNC_VLOW_IDX];

   // ---------------- glitch filters ----------------
   logic [NUM_STB-1:0] stb_f;
   for (genvar i = 0; i < NUM_STB; i++) begin : g_filt
      fbg_filt #(
         .HOLD   (GLITCH_CYC),
         .RST_VAL(1'b1)
      ) u_filt (
         .clk  (clk),
         .rst_n(por_n),
         .x_i  (sync_q[i]),
         .y_o  (stb_f[i])
      );
   end

   logic ce_f, oe_f, we_f;
   assign ce_f = stb_f[STB_CE];
   assign oe_f = stb_f[STB_OE];
   assign we_f = stb_f[STB_WE];

   // ---------------- reset pulse qualification ----------------
   logic rst_hit;
   fbg_rst_timer #(
      .MIN_CYC(RST_MIN_CYC)
   ) u_rst_timer (
      .clk    (clk),
      .rst_n  (por_n),
      .pin_s_i(rst_s),
      .hit_o  (rst_hit)
   );

   // ---------------- power-up lockout ----------------
   logic [SW-1:0] settle_q;
   logic          settled, pu_lock_q;
   assign settled = (settle_q == SETTLE_V);

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         settle_q  <= '0;
         pu_lock_q <= 1'b1;
      end else begin
         if (!settled) settle_q <= settle_q + 1'b1;
         if (settled && ce_f && we_f) pu_lock_q <= 1'b0;
      end
   end

   // ---------------- write cycle detection ----------------
   logic ce_q, we_q, hit_q, vlow_q;
   logic cyc_open, cyc_close, wr_ok;
   assign cyc_open  = !ce_q && !we_q;
   assign cyc_close = cyc_open && (ce_f || we_f);
   assign wr_ok     = oe_f && rst_s && !vlow_s && !pu_lock_q;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         ce_q        <= 1'b1;
         we_q        <= 1'b1;
         hit_q       <= 1'b0;
         vlow_q      <= 1'b1;
         wr_accept_o <= 1'b0;
         abort_o     <= 1'b0;
      end else begin
         ce_q        <= ce_f;
         we_q        <= we_f;
         hit_q       <= rst_hit;
         vlow_q      <= vlow_s;
         wr_accept_o <= cyc_close && wr_ok;
         abort_o     <= busy_i && ((rst_hit && !hit_q) || (vlow_s && !vlow_q));
      end
   end

   // ---------------- output gating ----------------
   assign sm_reset_o = rst_hit || vlow_s || pu_lock_q;
   assign dq_oe_o    = !ce_f && !oe_f && !rst_hit;
   assign standby_o  = ce_f && rst_s && !busy_i;

   // ---------------- assertions ----------------
   a_r2_no_write_in_reset: assert property (@(posedge clk) disable iff (!por_n)
      !rst_s |=> !wr_accept_o);
   a_r3_no_write_low_vcc: assert property (@(posedge clk) disable iff (!por_n)
      vlow_s |=> !wr_accept_o);
   a_r5_single_pulse: assert property (@(posedge clk) disable iff (!por_n)
      wr_accept_o |=> !wr_accept_o);
   a_r5_needs_oe_high: assert property (@(posedge clk) disable iff (!por_n)
      !oe_f |=> !wr_accept_o);
   a_r6_power_up_lock: assert property (@(posedge clk) disable iff (!por_n)
      pu_lock_q |=> !wr_accept_o);
   a_r1_abort_single: assert property (@(posedge clk) disable iff (!por_n)
      abort_o |=> !abort_o);
   a_r8_busy_no_standby: assert property (@(posedge clk) disable iff (!por_n)
      busy_i |-> !standby_o);
endmodule

// File: tb/flash_bus_gate_tb.sv
`timescale 1ns/1ps
module flash_bus_gate_tb;
   logic clk = 1'b0;
   logic por_n, ce_n, oe_n, we_n, rpin_n, vlow, busy;
   logic wr_acc, dq_oe, sm_rst, abort_p, stby;

   always #4 clk = ~clk;   // 125 MHz

   flash_bus_gate #(
      .SYNC_STAGES(2),
      .GLITCH_CYC (4),
      .RST_MIN_CYC(16)
   ) u_dut (
      .clk        (clk),
      .por_n      (por_n),
      .ce_n_i     (ce_n),
      .oe_n_i     (oe_n),
      .we_n_i     (we_n),
      .rst_pin_n_i(rpin_n),
      .vlow_i     (vlow),
      .busy_i     (busy),
      .wr_accept_o(wr_acc),
      .dq_oe_o    (dq_oe),
      .sm_reset_o (sm_rst),
      .abort_o    (abort_p),
      .standby_o  (stby)
   );

   int n_chk = 0, n_fail = 0;
   int acc_cnt = 0, abort_cnt = 0, smr_cnt = 0;

   always @(posedge clk) begin
      if (wr_acc)  acc_cnt++;
      if (abort_p) abort_cnt++;
      if (sm_rst)  smr_cnt++;
   end

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   // a full write: both low, then raise one strobe, then the other
   task automatic do_write(input bit end_on_ce);
      ce_n = 1'b0; we_n = 1'b0; cyc(15);
      if (end_on_ce) ce_n = 1'b1; else we_n = 1'b1;
      cyc(15);
      ce_n = 1'b1; we_n = 1'b1; cyc(15);
   endtask

   task automatic t_power_up;
      int a0;
      por_n = 1'b0; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
      rpin_n = 1'b0; vlow = 1'b0; busy = 1'b0;
      cyc(3);
      check("R6 reset state wr_accept", wr_acc, 0);
      check("R6 reset state sm_reset", sm_rst, 1);
      check("R7 reset state dq_oe", dq_oe, 0);
      check("R1 reset state abort", abort_p, 0);
      por_n = 1'b1; cyc(30);
      rpin_n = 1'b1; cyc(30);
      a0 = acc_cnt;
      we_n = 1'b1; cyc(20);
      check("R6 WE rise after power-up ignored", acc_cnt - a0, 0);
      check("R6 sm_reset held while locked", sm_rst, 1);
      ce_n = 1'b1; cyc(20);
      check("R6 lock released once idle", sm_rst, 0);
   endtask

   task automatic t_writes;
      int a0 = acc_cnt;
      do_write(1'b0);
      check("R5 write closed by WE", acc_cnt - a0, 1);
      a0 = acc_cnt;
      do_write(1'b1);
      check("R5 write closed by CE", acc_cnt - a0, 1);
      a0 = acc_cnt;
      oe_n = 1'b0; do_write(1'b0); oe_n = 1'b1; cyc(15);
      check("R5 write with OE low discarded", acc_cnt - a0, 0);
   endtask

   task automatic t_glitch;
      int a0 = acc_cnt;
      ce_n = 1'b0; we_n = 1'b0; cyc(15);
      we_n = 1'b1; cyc(2); we_n = 1'b0; cyc(15);
      check("R4 WE high glitch ignored", acc_cnt - a0, 0);
      we_n = 1'b1; cyc(15);
      check("R4 real WE rise accepted", acc_cnt - a0, 1);
      ce_n = 1'b1; cyc(15);
      a0 = acc_cnt;
      we_n = 1'b0; cyc(15);
      ce_n = 1'b0; cyc(2); ce_n = 1'b1; cyc(20);
      we_n = 1'b1; cyc(15);
      check("R4 CE low glitch opens no cycle", acc_cnt - a0, 0);
   endtask

   task automatic t_short_reset;
      int ab0 = abort_cnt, sm0 = smr_cnt, a0;
      busy = 1'b1;
      rpin_n = 1'b0; cyc(8); rpin_n = 1'b1; cyc(15);
      check("R2 short reset no abort", abort_cnt - ab0, 0);
      check("R2 short reset no sm_reset", smr_cnt - sm0, 0);
      busy = 1'b0;
      // write closed while reset pin is low (below qualification width)
      ce_n = 1'b0; we_n = 1'b0; cyc(15);
      a0 = acc_cnt;
      rpin_n = 1'b0; cyc(3); we_n = 1'b1; cyc(8);
      rpin_n = 1'b1; ce_n = 1'b1; cyc(20);
      check("R2 write during short reset blocked", acc_cnt - a0, 0);
   endtask

   task automatic t_long_reset;
      int ab0 = abort_cnt, a0;
      busy = 1'b1; ce_n = 1'b0; oe_n = 1'b0; cyc(15);
      check("R7 outputs drive before reset", dq_oe, 1);
      rpin_n = 1'b0; cyc(30);
      check("R1 long reset sm_reset", sm_rst, 1);
      check("R1 long reset outputs off", dq_oe, 0);
      check("R1 long reset abort once", abort_cnt - ab0, 1);
      busy = 1'b0; oe_n = 1'b1; ce_n = 1'b1; cyc(15);
      a0 = acc_cnt;
      do_write(1'b0);
      check("R2 write during long reset blocked", acc_cnt - a0, 0);
      rpin_n = 1'b1; cyc(15);
      check("R1 release clears sm_reset", sm_rst, 0);
   endtask

   task automatic t_vlow;
      int ab0 = abort_cnt, a0;
      busy = 1'b1; vlow = 1'b1; cyc(10);
      check("R3 low supply sm_reset", sm_rst, 1);
      check("R3 low supply abort once", abort_cnt - ab0, 1);
      busy = 1'b0;
      a0 = acc_cnt;
      do_write(1'b1);
      check("R3 write under low supply blocked", acc_cnt - a0, 0);
      vlow = 1'b0; cyc(10);
      a0 = acc_cnt;
      do_write(1'b1);
      check("R3 write after supply recovers", acc_cnt - a0, 1);
   endtask

   task automatic t_outputs;
      ce_n = 1'b1; oe_n = 1'b0; busy = 1'b0; cyc(15);
      check("R7 CE high outputs off", dq_oe, 0);
      check("R8 standby when deselected", stby, 1);
      busy = 1'b1; cyc(2);
      check("R8 busy keeps part active", stby, 0);
      busy = 1'b0; cyc(2);
      check("R8 standby after busy falls", stby, 1);
      ce_n = 1'b0; cyc(15);
      check("R7 CE and OE low drive", dq_oe, 1);
      check("R8 selected not standby", stby, 0);
      oe_n = 1'b1; cyc(15);
      check("R7 OE high outputs off", dq_oe, 0);
      ce_n = 1'b1; rpin_n = 1'b0; cyc(6);
      check("R8 reset pin low not standby", stby, 0);
      rpin_n = 1'b1; cyc(15);
   endtask

   initial begin
      t_power_up();
      t_writes();
      t_glitch();
      t_short_reset();
      t_long_reset();
      t_vlow();
      t_outputs();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule